// File: doc/BRIEF.md
# CRC-6 Copy-Control Word Builder

This block assembles a copy-control word from data held in user registers. It can also append an automatically computed 6-bit check field. Two formats are supported. The short format takes a 14-bit payload and yields a 20-bit word. The long format takes a 128-bit header-plus-payload and yields a 134-bit packet. In both cases the check field fills the six most significant bits of the result.

The check field is computed serially, one message bit per clock, after a one-cycle start pulse. A one-cycle done pulse marks the moment the assembled word is valid on the output. Each format has its own check-enable. When the enable for the chosen format is low, the full user word, including its upper six bits, is copied to the output unchanged. In that case done follows in the same cycle that accepts start. Line timing and serialisation onto video are handled elsewhere.

Top module: `copyWordBuilder`

## Requirements
- R1: The check field is produced by a 6-bit shift register for the polynomial x^6+x+1. Message bits enter from bit 0 upward. Per bit, fb = msgBit XOR crc[5], and the register becomes {crc[4:0],0} XOR {0000,fb,fb}.
- R2: The check register is loaded with 111111 when a job is accepted, before the first message bit.
- R3: Short format with check enabled: wordOut[13:0] equals wordA[13:0], wordOut[14+k] equals crc[k] for k=0..5, and wordOut[133:20] is zero.
- R4: Long format with check enabled: wordOut[127:0] equals wordB[127:0], and wordOut[128+k] equals crc[k] for k=0..5.
- R5: Short format with crcEnA low: wordOut equals wordA (all 20 bits) zero-extended to 134 bits.
- R6: Long format with crcEnB low: wordOut equals all 134 bits of wordB.
- R7: The enables are independent. Only crcEnA affects short-format jobs (typeSel=0), and only crcEnB affects long-format jobs (typeSel=1).
- R8: done is a one-cycle pulse. With the check enabled, it rises at the 14th (short) or 128th (long) clock edge after the edge that accepts start. In bypass, it rises at the accepting edge itself.
- R9: start is accepted only while busy is low. Inputs and start pulses that arrive while busy is high do not change the job's result.
- R10: After reset, done and busy are low and wordOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to build a word |
| typeSel | input | 1 | 0 = 20-bit short format, 1 = 134-bit long format |
| crcEnA | input | 1 | Automatic check field for short format |
| crcEnB | input | 1 | Automatic check field for long format |
| wordA | input | 20 | Short-format user word (bits 19:14 used only in bypass) |
| wordB | input | 134 | Long-format user word (bits 133:128 used only in bypass) |
| busy | output | 1 | Serial calculation in progress |
| done | output | 1 | One-cycle pulse: wordOut valid |
| wordOut | output | 134 | Assembled word |

## Verification
All-zero and all-one payloads in both formats expose the check register's preset. A missing preset gives an all-zero check for a zero payload, and a wrong tap gives a mismatch for the all-ones payload. Mixed patterns catch a reversed feed order or a reversed check field, both of which would scramble the upper bits. Each format is also run with the other format's enable toggled. A design that shared the enables would then bypass or compute when it should not. A start pulse with different data in the middle of a long job confirms that the running job is not restarted or corrupted, and each job's latency is counted so that an off-by-one counter is reported.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int A_MSG_W = 14;
  localparam int B_MSG_W = 128;
  localparam int CRC_W   = 6;
  localparam int A_WORD_W = A_MSG_W + CRC_W;
  localparam int WORD_W  = B_MSG_W + CRC_W;
  localparam int IDX_W   = $clog2(B_MSG_W);

  typedef enum logic {MODE_A = 1'b0, MODE_B = 1'b1} cwMode_t;

  typedef struct packed {
    logic             load;
    logic             shift;
    logic             finishCrc;
    logic             finishBypass;
    logic [IDX_W-1:0] bitIdx;
  } cwbStrobe_t;
endpackage

// File: rtl/cwbCtrl.sv
module cwbCtrl
  import cwb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  cwMode_t    modeIn,
  input  logic       crcEnA,
  input  logic       crcEnB,
  output cwbStrobe_t strb,
  output logic       busy,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  cwMode_t          modeReg;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] lastIdx;
  logic             crcWanted;

  assign crcWanted = (modeIn == MODE_B) ? crcEnB : crcEnA;
  assign lastIdx   = (modeReg == MODE_B) ? IDX_W'(B_MSG_W - 1) : IDX_W'(A_MSG_W - 1);

  always_comb begin
    strb = '0;
    strb.bitIdx = cnt;
    if (state == ST_IDLE) begin
      if (start) begin
        strb.load = 1'b1;
        strb.finishBypass = !crcWanted;
      end
    end else begin
      strb.shift = 1'b1;
      strb.finishCrc = (cnt == lastIdx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= MODE_A;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          modeReg <= modeIn;
          cnt     <= '0;
          if (crcWanted) state <= ST_RUN;
          else           done  <= 1'b1;
        end
      end else if (cnt == lastIdx) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);

  // R8: done never overlaps a running calculation
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: busy only starts from an accepted start pulse
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R8: bit counter stays inside the message
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= lastIdx));
endmodule

// File: rtl/cwbData.sv
module cwbData
  import cwb_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_PRESET = '1,
  parameter logic [CRC_W-1:0] POLY_LOW   = 6'b000011
)(
  input  logic                clk,
  input  logic                rstN,
  input  cwbStrobe_t          strb,
  input  cwMode_t             modeIn,
  input  logic [A_WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0]   wordB,
  output logic [WORD_W-1:0]   wordOut
);
  logic [B_MSG_W-1:0] msgReg;
  logic [CRC_W-1:0]   crcReg;
  logic [CRC_W-1:0]   crcNext;
  logic               fb;
  cwMode_t            modeReg;
  logic [WORD_W-1:0]  bypassWord;

  assign fb      = msgReg[strb.bitIdx] ^ crcReg[CRC_W-1];
  assign crcNext = {crcReg[CRC_W-2:0], 1'b0} ^ (fb ? POLY_LOW : '0);

  assign bypassWord = (modeIn == MODE_B) ? wordB
                                         : {{(WORD_W-A_WORD_W){1'b0}}, wordA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgReg  <= '0;
      crcReg  <= '0;
      modeReg <= MODE_A;
      wordOut <= '0;
    end else begin
      if (strb.load) begin
        msgReg  <= (modeIn == MODE_B) ? wordB[B_MSG_W-1:0]
                                      : {{(B_MSG_W-A_MSG_W){1'b0}}, wordA[A_MSG_W-1:0]};
        crcReg  <= CRC_PRESET;
        modeReg <= modeIn;
      end else if (strb.shift) begin
        crcReg <= crcNext;
      end
      if (strb.finishBypass) begin
        wordOut <= bypassWord;
      end else if (strb.finishCrc) begin
        if (modeReg == MODE_B)
          wordOut <= {crcNext, msgReg};
        else
          wordOut <= {{(WORD_W-A_WORD_W){1'b0}}, crcNext, msgReg[A_MSG_W-1:0]};
      end
    end
  end

  // R2: check register starts every job at the preset
  assert_preset_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (crcReg == CRC_PRESET));
  // R9: message held steady during the serial run
  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> $stable(msgReg));
  // R5, R6: bypass result equals the word presented at acceptance
  assert_bypass_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishBypass |=> (wordOut == $past(bypassWord)));
  // R3: short format keeps upper output bits zero after a computed job
  assert_short_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishCrc && modeReg == MODE_A) |=> (wordOut[WORD_W-1:A_WORD_W] == '0));
endmodule

// File: rtl/copyWordBuilder.sv
module copyWordBuilder
  import cwb_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_PRESET = '1,
  parameter logic [CRC_W-1:0] POLY_LOW   = 6'b000011
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                typeSel,
  input  logic                crcEnA,
  input  logic                crcEnB,
  input  logic [A_WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0]   wordB,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   wordOut
);
  cwbStrobe_t strb;
  cwMode_t    modeIn;

  assign modeIn = cwMode_t'(typeSel);

  cwbCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeIn),
    .crcEnA(crcEnA), .crcEnB(crcEnB), .strb(strb), .busy(busy), .done(done)
  );

  cwbData #(.CRC_PRESET(CRC_PRESET), .POLY_LOW(POLY_LOW)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .modeIn(modeIn),
    .wordA(wordA), .wordB(wordB), .wordOut(wordOut)
  );
endmodule

// File: tb/test_copyWordBuilder.sv
module test_copyWordBuilder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         typeSel = 1'b0;
  logic         crcEnA = 1'b0;
  logic         crcEnB = 1'b0;
  logic [19:0]  wordA = '0;
  logic [133:0] wordB = '0;
  logic         busy, done;
  logic [133:0] wordOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [133:0] expQ[$];
  string        tagQ[$];

  always #4 clk = ~clk;  // 125 MHz

  copyWordBuilder i_copyWordBuilder (
    .clk(clk), .rstN(rstN), .start(start), .typeSel(typeSel),
    .crcEnA(crcEnA), .crcEnB(crcEnB), .wordA(wordA), .wordB(wordB),
    .busy(busy), .done(done), .wordOut(wordOut)
  );

  // Reference: R1 polynomial, R2 preset, bit 0 first
  function automatic logic [5:0] refCrc(input logic [127:0] m, input int n);
    logic [5:0] c = 6'h3F;
    for (int i = 0; i < n; i++) begin
      logic f = m[i] ^ c[5];
      c = {c[4:0], 1'b0} ^ {4'b0, f, f};
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [133:0] act, input logic [133:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected words when done pulses
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check("R8 unexpected done", 134'd1, 134'd0);
      else check(tagQ.pop_front(), wordOut, expQ.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Driver: pushes expectation, runs a job, measures latency
  task automatic runJob(input string tag, input logic ts, input logic enA, input logic enB,
                        input logic [19:0] a, input logic [133:0] b, input bit midStart);
    logic [133:0] exp;
    int expLat, lat;
    bit calc = ts ? enB : enA;
    if (!ts) exp = calc ? {114'b0, refCrc({114'b0, a[13:0]}, 14), a[13:0]} : {114'b0, a};
    else     exp = calc ? {refCrc(b[127:0], 128), b[127:0]} : b;
    expLat = calc ? (ts ? 128 : 14) : 0;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    typeSel = ts; crcEnA = enA; crcEnB = enB; wordA = a; wordB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin
      if (midStart && lat == 3) begin
        start = 1'b1; typeSel = ~ts; wordA = ~a; wordB = ~b;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " R8 latency"}, 134'(lat), 134'(expLat));
    check({tag, " R9 busy low at done"}, 134'(busy), 134'd0);
    @(negedge clk);
    check({tag, " R8 done single pulse"}, 134'(done), 134'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset done", 134'(done), 134'd0);
    check("R10 reset busy", 134'(busy), 134'd0);
    check("R10 reset wordOut", wordOut, 134'd0);
    rstN = 1'b1;
    runJob("R3 A zeros",      1'b0, 1'b1, 1'b0, 20'h00000, '0, 1'b0);
    runJob("R3 A ones",       1'b0, 1'b1, 1'b0, 20'hFFFFF, '0, 1'b0);
    runJob("R1 A pattern",    1'b0, 1'b1, 1'b0, 20'h12A5C, '0, 1'b0);
    runJob("R2 A single bit", 1'b0, 1'b1, 1'b1, 20'h00001, '0, 1'b0);
    runJob("R4 B zeros",      1'b1, 1'b0, 1'b1, 20'h0, '0, 1'b0);
    runJob("R4 B ones",       1'b1, 1'b0, 1'b1, 20'h0, '1, 1'b0);
    runJob("R1 B pattern",    1'b1, 1'b0, 1'b1, 20'h0,
           {6'h15, 64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687}, 1'b0);
    runJob("R5 A bypass",     1'b0, 1'b0, 1'b1, 20'hABCDE, '0, 1'b0);
    runJob("R6 B bypass",     1'b1, 1'b1, 1'b0, 20'h0,
           {6'h2A, 64'hDEAD_BEEF_0000_FFFF, 64'h5555_AAAA_3333_CCCC}, 1'b0);
    runJob("R7 A on B off",   1'b0, 1'b1, 1'b0, 20'hF3C21, '0, 1'b0);
    runJob("R7 B on A off",   1'b1, 1'b0, 1'b1, 20'h0,
           {6'h3F, 64'h1, 64'h8000_0000_0000_0000}, 1'b0);
    runJob("R9 start while busy", 1'b1, 1'b0, 1'b1, 20'h0,
           {6'h00, 64'hCAFE_F00D_1234_5678, 64'h0F0F_0F0F_F0F0_F0F0}, 1'b1);
    runJob("R9 A after busy", 1'b0, 1'b1, 1'b0, 20'h3A5A5, '0, 1'b0);
    repeat (4) @(negedge clk);
    check("R8 all results seen", 134'(expQ.size()), 134'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule